// File: doc/BRIEF.md
# Word Memory with Built-in Stack Engine

This block is a 1024-word by 32-bit data memory with two ways in. A load/store port reads and writes any word by address. A stack engine shares the same storage. It keeps its own pointer, which starts at the last word (1023) and grows downward. A push first moves the pointer down one word and then writes the word there. A pop reads the word under the pointer, returns it, and then moves the pointer up one word.

Requests arrive on one valid/ready channel, with at most one accepted per clock. Loads and pops answer one cycle after acceptance, on a response channel. The response carries the data word and the destination tag that came with the request, so the consumer can steer the word into the right register.

Any access that falls outside the storage is trapped, and nothing is changed. The access may be an address at or above 1024, a push with the pointer at 0, or a pop with the pointer above 1023. A trapped access raises a sticky error flag, which stays set until reset or an explicit clear. A trapped read returns zero. A synchronous reset zeroes every word and puts the pointer back at 1023.

Top module: `stackmem_core`

## Requirements
- R1: While `rst_n` is low for at least one rising edge, every word becomes zero, `stack_ptr` becomes 1023, `mem_err` and `rsp_valid` go low, and `req_ready` is high from the first edge after reset is released.
- R2: An operation is accepted on a rising edge with `req_valid` and `req_ready` high. `req_op` encodes the operation: 0 is load, 1 is store, 2 is push, 3 is pop. A store writes `req_wdata` to word `req_addr`. A load of `req_addr` raises `rsp_valid` for one cycle after the accepting edge, with the word on `rsp_data` and `req_tag` on `rsp_tag`.
- R3: A load with `req_addr` of 1024 or more returns `rsp_valid` with `rsp_data` equal to zero and sets `mem_err`.
- R4: A store with `req_addr` of 1024 or more writes no word at all (in particular not the word the low address bits point at) and sets `mem_err`.
- R5: A push with `stack_ptr` above 0 decrements `stack_ptr` and writes the pushed word at the new pointer. `req_imm_sel` picks the pushed word: 1 takes `req_imm`, 0 takes `req_wdata`.
- R6: A pop with `stack_ptr` at most 1023 returns the word at `stack_ptr` on `rsp_data` with `req_tag` on `rsp_tag`, one cycle after acceptance, and increments `stack_ptr`.
- R7: A push with `stack_ptr` equal to 0 sets `mem_err`, leaves `stack_ptr` at 0 and writes no word.
- R8: A pop with `stack_ptr` equal to 1024 sets `mem_err`, leaves `stack_ptr` unchanged and returns `rsp_valid` with `rsp_data` zero and the request tag.
- R9: `mem_err` stays high until reset or a cycle with `err_clear` high. When `err_clear` coincides with a trapped access, the flag ends set.
- R10: Store and push accesses produce no response (`rsp_valid` stays low), and `stack_ptr` changes only on an accepted push or pop.
- R11: Stack and load/store accesses use the same storage: a pushed word can be read back by a load of its pointer address, and a stored word can be popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 push, 3 pop |
| req_addr | input | 32 | Word address for load and store |
| req_wdata | input | 32 | Store data, or register operand for push |
| req_imm | input | 32 | Immediate word for push |
| req_imm_sel | input | 1 | Push source: 1 immediate, 0 register operand |
| req_tag | input | 6 | Destination tag returned with load/pop data |
| err_clear | input | 1 | Clears the sticky error flag |
| rsp_valid | output | 1 | Response data valid this cycle |
| rsp_data | output | 32 | Loaded or popped word (zero when trapped) |
| rsp_tag | output | 6 | Tag of the answered request |
| mem_err | output | 1 | Sticky out-of-range error |
| stack_ptr | output | 11 | Current stack pointer |

## Verification
Load/store is exercised with all-ones, alternating-bit and mixed patterns at address 0, at 1023 and in the middle. A wrong address index or a lost bit shows up there. Out-of-range traffic uses 1024, 1029 and all-ones addresses. The 1029 store sits on top of a known value at word 5, so a store that wraps through the low address bits is caught. The stack is driven with the two push sources carrying different values, so a swapped select is visible. It is also driven through both ends: a full descent of 1023 pushes to pointer 0, and pops past 1023. These separate a wrong pre/post pointer order from a wrong bound check. A coincident clear and fault decides the priority of the sticky flag.

// File: rtl/stackmem_pkg.sv
package stackmem_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_PUSH  = 2'd2,
        OP_POP   = 2'd3
    } mem_op_e;

endpackage

// File: rtl/stackmem_range_chk.sv
module stackmem_range_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    always_comb begin
        in_range = (addr < LIMIT);
        idx      = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/stackmem_array.sv
module stackmem_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Storage is cleared word by word on reset; otherwise one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/stackmem_stack_ctl.sv
module stackmem_stack_ctl #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int SP_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_go,
    input  logic             pop_go,
    output logic [SP_W-1:0]  sp,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] pop_idx
);
    localparam logic [SP_W-1:0] SP_TOP = SP_W'(DEPTH - 1);
    localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

    typedef struct packed {
        logic [SP_W-1:0] sp;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        push_ok  = (st_q.sp != '0);
        pop_ok   = (st_q.sp <= SP_TOP);
        push_idx = IDX_W'(st_q.sp - SP_ONE);
        pop_idx  = st_q.sp[IDX_W-1:0];
        st_d     = st_q;
        if (push_go && push_ok)
            st_d.sp = st_q.sp - SP_ONE;
        else if (pop_go && pop_ok)
            st_d.sp = st_q.sp + SP_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sp <= SP_TOP;
        else        st_q    <= st_d;
    end

    assign sp = st_q.sp;

    // The pointer never leaves 0..DEPTH.
    assert_sp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH));

    assert_push_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_go && sp == '0) |=> sp == '0);

    assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_go && sp <= SP_TOP) |=> sp == $past(sp) + SP_ONE);

    assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_go && sp != '0) |=> sp == $past(sp) - SP_ONE);

    assert_sp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_go || pop_go) |=> $stable(sp));
endmodule

// File: rtl/stackmem_core.sv
module stackmem_core
    import stackmem_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W-1:0]      req_imm,
    input  logic                   req_imm_sel,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic                   err_clear,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic [TAG_W-1:0]       rsp_tag,
    output logic                   mem_err,
    output logic [$clog2(DEPTH):0] stack_ptr
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SP_W  = IDX_W + 1;

    typedef struct packed {
        logic              ready;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic [TAG_W-1:0]  rsp_tag;
        logic              err;
    } core_state_t;

    core_state_t st_d, st_q;

    mem_op_e           op;
    logic              accept;
    logic              addr_ok;
    logic [IDX_W-1:0]  addr_idx;
    logic              push_go, pop_go, push_ok, pop_ok;
    logic [IDX_W-1:0]  push_idx, pop_idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              fault;

    assign op     = mem_op_e'(req_op);
    assign accept = req_valid && st_q.ready;
    assign push_go = accept && (op == OP_PUSH);
    assign pop_go  = accept && (op == OP_POP);

    stackmem_range_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_range (
        .addr     (req_addr),
        .in_range (addr_ok),
        .idx      (addr_idx)
    );

    stackmem_stack_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SP_W(SP_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_go  (push_go),
        .pop_go   (pop_go),
        .sp       (stack_ptr),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .push_idx (push_idx),
        .pop_idx  (pop_idx)
    );

    stackmem_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Steering of the single storage port pair and next-state computation.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = addr_idx;
        wr_data = req_wdata;
        rd_idx  = addr_idx;
        fault   = 1'b0;
        st_d    = st_q;

        st_d.ready     = 1'b1;
        st_d.rsp_valid = 1'b0;

        if (accept) begin
            unique case (op)
                OP_LOAD: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_tag   = req_tag;
                    st_d.rsp_data  = addr_ok ? rd_data : '0;
                    fault          = !addr_ok;
                end
                OP_STORE: begin
                    wr_en = addr_ok;
                    fault = !addr_ok;
                end
                OP_PUSH: begin
                    wr_en   = push_ok;
                    wr_idx  = push_idx;
                    wr_data = req_imm_sel ? req_imm : req_wdata;
                    fault   = !push_ok;
                end
                OP_POP: begin
                    rd_idx         = pop_idx;
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_tag   = req_tag;
                    st_d.rsp_data  = pop_ok ? rd_data : '0;
                    fault          = !pop_ok;
                end
                default: ;
            endcase
        end

        if (err_clear) st_d.err = 1'b0;
        if (fault)     st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = st_q.ready;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_tag   = st_q.rsp_tag;
    assign mem_err   = st_q.err;

    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 2'd0 || req_op == 2'd3)) |=>
            (rsp_valid && rsp_tag == $past(req_tag)));

    assert_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && (req_op == 2'd0 || req_op == 2'd3)) |=> !rsp_valid);

    assert_oor_load_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd0 && !addr_ok) |=>
            (mem_err && rsp_data == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err && !err_clear) |=> mem_err);

    assert_oor_store_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd1 && !addr_ok) |-> !wr_en);
endmodule

// File: tb/stackmem_core_tb.sv
module stackmem_core_tb;
    localparam int DEPTH  = 1024;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 6;
    localparam int SP_W   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] req_imm = '0;
    logic              req_imm_sel = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              err_clear = 1'b0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0]  rsp_tag;
    logic              mem_err;
    logic [SP_W-1:0]   stack_ptr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stackmem_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_imm(req_imm),
        .req_imm_sel(req_imm_sel), .req_tag(req_tag), .err_clear(err_clear),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .mem_err(mem_err), .stack_ptr(stack_ptr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge; it is accepted at the next rising edge.
    // On return (next falling edge) the registered outputs show its effect.
    task automatic issue(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [31:0] imm, input logic sel, input logic [5:0] tag,
                         input logic clr);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        req_imm = imm; req_imm_sel = sel; req_tag = tag; err_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; err_clear = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_chk(input string req, input logic [31:0] addr,
                            input logic [31:0] exp, input logic [5:0] tag);
        issue(2'd0, addr, 32'h0, 32'h0, 1'b0, tag, 1'b0);
        chk(req, "load rsp_valid", 32'(rsp_valid), 32'd1);
        chk(req, "load data", rsp_data, exp);
        chk(req, "load tag", 32'(rsp_tag), 32'(tag));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "stack_ptr after reset", 32'(stack_ptr), 32'd1023);
        chk("R1", "mem_err after reset", 32'(mem_err), 32'd0);
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        issue(2'd1, 32'd7, 32'hA5A5_0F0F, 32'h0, 1'b0, 6'd0, 1'b0);
        issue(2'd2, 32'd0, 32'h1111_2222, 32'h0, 1'b0, 6'd0, 1'b0);
        do_reset();
        load_chk("R1", 32'd7, 32'h0, 6'd1);
        load_chk("R1", 32'd1022, 32'h0, 6'd2);
        chk("R1", "stack_ptr restored", 32'(stack_ptr), 32'd1023);
    endtask

    task automatic t_load_store();
        do_reset();
        issue(2'd1, 32'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 6'd0, 1'b0);
        chk("R10", "store gives no response", 32'(rsp_valid), 32'd0);
        chk("R10", "store keeps stack_ptr", 32'(stack_ptr), 32'd1023);
        issue(2'd1, 32'd1023, 32'h5555_AAAA, 32'h0, 1'b0, 6'd0, 1'b0);
        issue(2'd1, 32'd512, 32'h1234_5678, 32'h0, 1'b0, 6'd0, 1'b0);
        load_chk("R2", 32'd0, 32'hFFFF_FFFF, 6'd3);
        load_chk("R2", 32'd1023, 32'h5555_AAAA, 6'd63);
        load_chk("R2", 32'd512, 32'h1234_5678, 6'd21);
        load_chk("R2", 32'd511, 32'h0, 6'd0);
        @(negedge clk);
        chk("R2", "response lasts one cycle", 32'(rsp_valid), 32'd0);
        chk("R2", "no error on legal traffic", 32'(mem_err), 32'd0);
    endtask

    task automatic t_range();
        do_reset();
        issue(2'd1, 32'd5, 32'hCAFE_F00D, 32'h0, 1'b0, 6'd0, 1'b0);
        load_chk("R3", 32'd1024, 32'h0, 6'd9);
        chk("R3", "mem_err on load 1024", 32'(mem_err), 32'd1);
        clear_only();
        chk("R9", "err_clear drops flag", 32'(mem_err), 32'd0);
        load_chk("R3", 32'hFFFF_FFFF, 32'h0, 6'd10);
        chk("R3", "mem_err on load all-ones", 32'(mem_err), 32'd1);
        clear_only();
        issue(2'd1, 32'd1029, 32'hDEAD_BEEF, 32'h0, 1'b0, 6'd0, 1'b0);
        chk("R4", "mem_err on store 1029", 32'(mem_err), 32'd1);
        load_chk("R4", 32'd5, 32'hCAFE_F00D, 6'd11);
    endtask

    task automatic t_sticky();
        do_reset();
        issue(2'd0, 32'd2000, 32'h0, 32'h0, 1'b0, 6'd0, 1'b0);
        load_chk("R9", 32'd5, 32'h0, 6'd1);
        issue(2'd1, 32'd6, 32'h77, 32'h0, 1'b0, 6'd0, 1'b0);
        chk("R9", "flag held across legal ops", 32'(mem_err), 32'd1);
        issue(2'd0, 32'd4096, 32'h0, 32'h0, 1'b0, 6'd0, 1'b1);
        chk("R9", "fault beats simultaneous clear", 32'(mem_err), 32'd1);
        issue(2'd0, 32'd6, 32'h0, 32'h0, 1'b0, 6'd0, 1'b1);
        chk("R9", "clear with legal op", 32'(mem_err), 32'd0);
        chk("R9", "data of legal op during clear", rsp_data, 32'h77);
    endtask

    task automatic t_push_pop();
        do_reset();
        issue(2'd1, 32'd1023, 32'hE0E0_E0E0, 32'h0, 1'b0, 6'd0, 1'b0);
        issue(2'd2, 32'd0, 32'hAAAA_0001, 32'hBBBB_0002, 1'b0, 6'd0, 1'b0);
        chk("R5", "push decrements", 32'(stack_ptr), 32'd1022);
        chk("R10", "push gives no response", 32'(rsp_valid), 32'd0);
        load_chk("R11", 32'd1022, 32'hAAAA_0001, 6'd4);
        issue(2'd2, 32'd0, 32'hCCCC_0003, 32'hDDDD_0004, 1'b1, 6'd0, 1'b0);
        chk("R5", "second push", 32'(stack_ptr), 32'd1021);
        load_chk("R5", 32'd1021, 32'hDDDD_0004, 6'd5);
        issue(2'd3, 32'd0, 32'h0, 32'h0, 1'b0, 6'd9, 1'b0);
        chk("R6", "pop valid", 32'(rsp_valid), 32'd1);
        chk("R6", "pop data immediate", rsp_data, 32'hDDDD_0004);
        chk("R6", "pop tag", 32'(rsp_tag), 32'd9);
        chk("R6", "pop increments", 32'(stack_ptr), 32'd1022);
        issue(2'd3, 32'd0, 32'h0, 32'h0, 1'b0, 6'd33, 1'b0);
        chk("R6", "pop data register", rsp_data, 32'hAAAA_0001);
        chk("R6", "pop tag 33", 32'(rsp_tag), 32'd33);
        issue(2'd3, 32'd0, 32'h0, 32'h0, 1'b0, 6'd12, 1'b0);
        chk("R11", "pop of stored top word", rsp_data, 32'hE0E0_E0E0);
        chk("R6", "pointer at 1024", 32'(stack_ptr), 32'd1024);
        chk("R6", "no error yet", 32'(mem_err), 32'd0);
        issue(2'd3, 32'd0, 32'h0, 32'h0, 1'b0, 6'd44, 1'b0);
        chk("R8", "empty pop valid", 32'(rsp_valid), 32'd1);
        chk("R8", "empty pop data zero", rsp_data, 32'h0);
        chk("R8", "empty pop tag", 32'(rsp_tag), 32'd44);
        chk("R8", "empty pop err", 32'(mem_err), 32'd1);
        chk("R8", "empty pop pointer kept", 32'(stack_ptr), 32'd1024);
    endtask

    task automatic t_underflow();
        do_reset();
        for (int i = 1; i <= 1023; i++)
            issue(2'd2, 32'd0, 32'h0, 32'h1000_0000 + 32'(i), 1'b1, 6'd0, 1'b0);
        chk("R5", "pointer after 1023 pushes", 32'(stack_ptr), 32'd0);
        chk("R5", "no error on full descent", 32'(mem_err), 32'd0);
        load_chk("R11", 32'd0, 32'h1000_03FF, 6'd7);
        issue(2'd2, 32'd0, 32'h0BAD_0BAD, 32'h0BAD_0BAD, 1'b0, 6'd0, 1'b0);
        chk("R7", "push at floor err", 32'(mem_err), 32'd1);
        chk("R7", "push at floor pointer", 32'(stack_ptr), 32'd0);
        load_chk("R7", 32'd1023, 32'h0, 6'd8);
        load_chk("R7", 32'd0, 32'h1000_03FF, 6'd9);
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_range();
        t_sticky();
        t_push_pop();
        t_underflow();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule